// File: doc/BRIEF.md
# Tiled Framebuffer Address Translator

This block sits between a linear framebuffer port and video memory. Every byte address that lands at or above a programmable tile base is remapped so that pixels are stored in tiles of 128 bytes by 32 lines. The offset past the base is split into a column x and a line y using a programmable line length. The tile that holds the pixel is then placed by a column step of 4 KiB per tile and a tile-row step set by a separate pitch value. Addresses below the tile base pass through unchanged.

Configuration comes from one 32-bit setup word and a tile-row pitch value. Each request carries a byte address and a write flag. The translated address is registered once and comes back one cycle later with a valid strobe. The block also compares the final address with the size of the video memory. A write that falls outside is suppressed. A read that falls outside is flagged so the data path returns all ones.

Top module: `tile_addr_xlat`

## Requirements
- R1: While reset is held, out_valid, out_wr_en and out_rd_ones are all 0.
- R2: A request with in_valid=1 on a clock edge produces out_valid=1 on the next edge, with out_addr, out_write and the flags for that request; with no request, out_valid is 0.
- R3: The tile base is cfg_word[12:0] multiplied by 4096. An address strictly below the tile base is returned unchanged.
- R4: cfg_word[15:13] selects the line length, 1024 << field bytes. With off = address − base, x is the low (10+field) bits of off and y is off >> (10+field).
- R5: An address at or above the base maps to base + (x mod 128) + (x div 128)·4096 + (y mod 32)·128 + (y div 32)·row_pitch, taken modulo 2^ADDR_W. An address equal to the base maps to the base.
- R6: row_pitch sets the distance between successive rows of tiles (every 32 lines).
- R7: out_oor is 1 exactly when the final address, translated or passed through, is greater than or equal to mem_limit.
- R8: For a read, out_rd_ones is 1 when out_oor is 1 and 0 otherwise; for a write it is 0.
- R9: For a write, out_wr_en is 1 only when out_oor is 0; for a read it is 0.
- R10: cfg_word[31:16] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous deassert |
| cfg_word | input | 32 | Setup word: tile base page in [12:0], line length select in [15:13] |
| row_pitch | input | PITCH_W | Byte distance between rows of tiles |
| mem_limit | input | ADDR_W | Size of video memory in bytes |
| in_valid | input | 1 | Request strobe |
| in_write | input | 1 | 1 for a write, 0 for a read |
| in_addr | input | ADDR_W | Linear byte address |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_write | output | 1 | Write flag of the request |
| out_addr | output | ADDR_W | Final video memory address |
| out_oor | output | 1 | Final address is at or beyond mem_limit |
| out_wr_en | output | 1 | Write allowed to memory |
| out_rd_ones | output | 1 | Read must return all ones |

## Verification
A wrong line length decode or a misplaced tile-base compare shows up as a wrong out_addr on the very next cycle after the request. Tile arithmetic errors show only for addresses whose x reaches 128 or whose y reaches 32, so the directed cases pick offsets that cross those boundaries. A range-compare fault shows at once as a wrong pairing of out_oor with out_wr_en or out_rd_ones, and the exact limit address is tested on both sides. A stuck output register shows as out_valid failing to follow in_valid by one cycle.

// File: rtl/tile_xlat_pkg.sv
package tile_xlat_pkg;
   localparam int TILE_W_LOG   = 7;   // 128-byte tile width
   localparam int TILE_H_LOG   = 5;   // 32-line tile height
   localparam int TILE_SZ_LOG  = TILE_W_LOG + TILE_H_LOG;
   localparam int BASE_SHIFT   = 12;
   localparam int LINE_LOG_MIN = 10;
   localparam int SHIFT_W      = 5;

   typedef struct packed {
      logic [15:0] unused_hi;
      logic [2:0]  line_sel;
      logic [12:0] base_page;
   } cfg_t;
endpackage

// File: rtl/tile_cfg_decode.sv
module tile_cfg_decode
   import tile_xlat_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [31:0]         cfg_word,
   output logic [ADDR_W-1:0]   tile_base,
   output logic [SHIFT_W-1:0]  line_shift
);
   cfg_t cfg;
   logic unused_cfg;

   assign cfg        = cfg_t'(cfg_word);
   assign unused_cfg = ^cfg.unused_hi;
   assign tile_base  = ADDR_W'(cfg.base_page) << BASE_SHIFT;
   assign line_shift = SHIFT_W'(LINE_LOG_MIN) + SHIFT_W'(cfg.line_sel);
endmodule

// File: rtl/tile_map_core.sv
module tile_map_core
   import tile_xlat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PITCH_W  = 24,
   parameter bit USE_MULT = 1'b1
) (
   input  logic [ADDR_W-1:0]   lin_addr,
   input  logic [ADDR_W-1:0]   tile_base,
   input  logic [SHIFT_W-1:0]  line_shift,
   input  logic [PITCH_W-1:0]  row_pitch,
   output logic [ADDR_W-1:0]   map_addr
);
   localparam logic [ADDR_W-1:0] COL_MASK  = ADDR_W'((1 << TILE_W_LOG) - 1);
   localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((1 << TILE_H_LOG) - 1);

   logic              below;
   logic [ADDR_W-1:0] off, low_mask, x_col, y_line, y_tile, pitch_ext;
   logic [ADDR_W-1:0] row_term, tiled;

   assign below     = lin_addr < tile_base;
   assign off       = lin_addr - tile_base;
   assign low_mask  = ~({ADDR_W{1'b1}} << line_shift);
   assign x_col     = off & low_mask;
   assign y_line    = off >> line_shift;
   assign y_tile    = y_line >> TILE_H_LOG;
   assign pitch_ext = ADDR_W'(row_pitch);

   generate
      if (USE_MULT) begin : g_mul
         assign row_term = y_tile * pitch_ext;
      end else begin : g_shadd
         always_comb begin
            row_term = '0;
            for (int i = 0; i < PITCH_W; i++) begin
               if (row_pitch[i]) row_term = row_term + (y_tile << i);
            end
         end
      end
   endgenerate

   assign tiled = tile_base
                + (x_col & COL_MASK)
                + ((x_col >> TILE_W_LOG) << TILE_SZ_LOG)
                + ((y_line & LINE_MASK) << TILE_W_LOG)
                + row_term;

   assign map_addr = below ? lin_addr : tiled;
endmodule

// File: rtl/tile_range_chk.sv
module tile_range_chk #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] limit,
   input  logic              is_write,
   output logic              oor,
   output logic              wr_ok,
   output logic              rd_ones
);
   assign oor     = addr >= limit;
   assign wr_ok   = is_write & ~oor;
   assign rd_ones = ~is_write & oor;
endmodule

// File: rtl/tile_addr_xlat.sv
module tile_addr_xlat
   import tile_xlat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PITCH_W  = 24,
   parameter bit USE_MULT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        cfg_word,
   input  logic [PITCH_W-1:0] row_pitch,
   input  logic [ADDR_W-1:0]  mem_limit,
   input  logic               in_valid,
   input  logic               in_write,
   input  logic [ADDR_W-1:0]  in_addr,
   output logic               out_valid,
   output logic               out_write,
   output logic [ADDR_W-1:0]  out_addr,
   output logic               out_oor,
   output logic               out_wr_en,
   output logic               out_rd_ones
);
   initial begin
      assert (ADDR_W >= BASE_SHIFT + 13)
         else $fatal(1, "ADDR_W too small for tile base field");
      assert (PITCH_W < ADDR_W)
         else $fatal(1, "PITCH_W must be narrower than ADDR_W");
   end

   logic [ADDR_W-1:0]  dec_base, map_addr;
   logic [SHIFT_W-1:0] dec_shift;
   logic               c_oor, c_wr_ok, c_rd_ones;

   tile_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .cfg_word   (cfg_word),
      .tile_base  (dec_base),
      .line_shift (dec_shift)
   );

   tile_map_core #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .USE_MULT(USE_MULT)) u_map (
      .lin_addr   (in_addr),
      .tile_base  (dec_base),
      .line_shift (dec_shift),
      .row_pitch  (row_pitch),
      .map_addr   (map_addr)
   );

   tile_range_chk #(.ADDR_W(ADDR_W)) u_rng (
      .addr     (map_addr),
      .limit    (mem_limit),
      .is_write (in_write),
      .oor      (c_oor),
      .wr_ok    (c_wr_ok),
      .rd_ones  (c_rd_ones)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_write   <= 1'b0;
         out_addr    <= '0;
         out_oor     <= 1'b0;
         out_wr_en   <= 1'b0;
         out_rd_ones <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_wr_en   <= in_valid & c_wr_ok;
         out_rd_ones <= in_valid & c_rd_ones;
         if (in_valid) begin
            out_write <= in_write;
            out_addr  <= map_addr;
            out_oor   <= c_oor;
         end
      end
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_wr_en && !out_rd_ones);

   // R3
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_addr < dec_base)) |=> (out_addr == $past(in_addr)));

   // R9
   wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en |-> (out_valid && out_write && !out_oor));

   // R8
   rd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_rd_ones |-> (out_valid && !out_write && out_oor));

   // R8
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_wr_en, out_rd_ones}));
endmodule

// File: tb/tile_addr_xlat_bench.sv
`timescale 1ns/1ps
module tile_addr_xlat_bench;
   localparam int AW = 32;
   localparam int PW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cfg_word = 32'h0;
   logic [PW-1:0] row_pitch = '0;
   logic [AW-1:0] mem_limit = 32'h0040_0000;
   logic          in_valid = 1'b0;
   logic          in_write = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          out_valid, out_write, out_oor, out_wr_en, out_rd_ones;
   logic [AW-1:0] out_addr;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tile_addr_xlat u_tile_addr_xlat (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .row_pitch(row_pitch),
      .mem_limit(mem_limit), .in_valid(in_valid), .in_write(in_write),
      .in_addr(in_addr), .out_valid(out_valid), .out_write(out_write),
      .out_addr(out_addr), .out_oor(out_oor), .out_wr_en(out_wr_en),
      .out_rd_ones(out_rd_ones)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] c,
                                         input logic [PW-1:0] p);
      logic [31:0] base, off, x, y;
      int sh;
      base = {19'd0, c[12:0]} << 12;
      if (a < base) return a;
      off = a - base;
      sh  = 10 + int'(c[15:13]);
      x   = off & ((32'd1 << sh) - 1);
      y   = off >> sh;
      return base + (x % 128) + (x / 128) * 4096 + (y % 32) * 128 + (y / 32) * {8'd0, p};
   endfunction

   // drive at negedge, result sampled one negedge later
   task automatic xfer(input logic [31:0] a, input logic wr);
      @(negedge clk);
      in_addr = a; in_write = wr; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 valid in reset", 32'(out_valid), 32'd0);
      chk("R1 wr_en in reset", 32'(out_wr_en), 32'd0);
      chk("R1 rd_ones in reset", 32'(out_rd_ones), 32'd0);
   endtask

   task automatic t_latency;
      xfer(32'h0000_0100, 1'b0);
      chk("R2 valid after request", 32'(out_valid), 32'd1);
      chk("R2 write flag follows", 32'(out_write), 32'd0);
      @(negedge clk);
      chk("R2 valid drops when idle", 32'(out_valid), 32'd0);
   endtask

   task automatic t_passthru;
      cfg_word = 32'h0000_0010;           // base 0x10000
      xfer(32'h0000_FFFF, 1'b0);
      chk("R3 just below base unchanged", out_addr, 32'h0000_FFFF);
      xfer(32'h0000_0000, 1'b0);
      chk("R3 zero unchanged", out_addr, 32'h0);
      xfer(32'h0001_0000, 1'b0);
      chk("R5 address equal to base", out_addr, 32'h0001_0000);
   endtask

   task automatic t_hand;
      cfg_word = 32'h0000_0001; row_pitch = 24'h01_0000;
      xfer(32'h0000_A4C8, 1'b0);          // x=200, y=37, line 1024
      chk("R5 hand-worked tiled address", out_addr, 32'h0001_22C8);
   endtask

   task automatic t_strides;
      row_pitch = 24'h00_8000;
      for (int f = 0; f < 8; f++) begin
         cfg_word = {16'd0, 3'(f), 13'h0003};
         xfer(32'h0000_3000 + (32'd77 << (10 + f)) + 32'd300, 1'b0);
         chk("R4 line length select", out_addr,
             model(32'h0000_3000 + (32'd77 << (10 + f)) + 32'd300, cfg_word, row_pitch));
      end
   endtask

   task automatic t_pitch;
      cfg_word = 32'h0000_2002;           // field 1 -> 2048-byte lines
      for (int k = 0; k < 4; k++) begin
         row_pitch = 24'h00_4000 + 24'(k) * 24'h00_1100;
         xfer(32'h0000_2000 + 32'd2048 * 32'd70 + 32'd1500, 1'b0);
         chk("R6 tile-row pitch", out_addr,
             model(32'h0000_2000 + 32'd2048 * 32'd70 + 32'd1500, cfg_word, row_pitch));
      end
   endtask

   task automatic t_range;
      cfg_word = 32'h0000_0001; row_pitch = 24'h01_0000;
      mem_limit = 32'h0001_22C8;
      xfer(32'h0000_A4C8, 1'b0);
      chk("R7 oor at exact limit", 32'(out_oor), 32'd1);
      chk("R8 read oor gives ones", 32'(out_rd_ones), 32'd1);
      chk("R9 read never enables write", 32'(out_wr_en), 32'd0);
      xfer(32'h0000_A4C8, 1'b1);
      chk("R9 write oor suppressed", 32'(out_wr_en), 32'd0);
      chk("R8 write never flags ones", 32'(out_rd_ones), 32'd0);
      mem_limit = 32'h0001_22C9;
      xfer(32'h0000_A4C8, 1'b1);
      chk("R7 in range one past", 32'(out_oor), 32'd0);
      chk("R9 write in range enabled", 32'(out_wr_en), 32'd1);
      xfer(32'h0000_A4C8, 1'b0);
      chk("R8 in-range read no ones", 32'(out_rd_ones), 32'd0);
      mem_limit = 32'h0000_0800;
      xfer(32'h0000_0900, 1'b0);
      chk("R7 passthrough range checked", 32'(out_oor), 32'd1);
      chk("R7 passthrough addr kept", out_addr, 32'h0000_0900);
      mem_limit = 32'h0040_0000;
   endtask

   task automatic t_ignored;
      cfg_word = 32'hFFFF_0001; row_pitch = 24'h01_0000;
      xfer(32'h0000_A4C8, 1'b0);
      chk("R10 high config bits ignored", out_addr, 32'h0001_22C8);
      cfg_word = 32'hA5A5_0001;
      xfer(32'h0000_0FFF, 1'b0);
      chk("R10 high bits leave base alone", out_addr, 32'h0000_0FFF);
   endtask

   initial begin
      #10;
      @(negedge clk);
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      t_latency;
      t_passthru;
      t_hand;
      t_strides;
      t_pitch;
      t_range;
      t_ignored;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule